// File: doc/BRIEF.md
# Reseeded Accumulator Test Pattern Generator

This block is a built-in self-test stimulus source. It produces test vectors by adding a constant to an n-bit accumulator on every cycle. A constant table, fixed at elaboration, lists the runs to apply. Each entry holds one stored word and a run length. The stored word serves two roles. It is the first vector of the run. It is also the per-cycle addend, once its lowest bit is forced high.

A start pulse launches the whole list. The controller walks the entries in index order and plays each run for its stated number of cycles. Runs follow one another with no gap, and entries of length zero are passed over. When the list ends, the valid strobe falls and a completion flag stays up until the next start. Because the addend is always odd, a run can last up to 2^n vectors before any vector repeats. Compaction of the responses and the logic under test live outside this block.

Top module: `accum_pattern_gen`

## Requirements
- R1: A synchronous active-high `rst` forces `pat_valid` low, `done` low and `pattern` to all zeros on the next clock edge.
- R2: When `start` is high at a clock edge while no run is in progress, the next cycle shows `pat_valid` high, `done` low, and `pattern` equal to the stored word of the lowest-index entry whose length is non-zero.
- R3: Within a run, each vector equals the previous vector plus (stored word with bit 0 set to 1), modulo 2^VEC_W, so the addition wraps on overflow.
- R4: An entry of length L gives exactly L consecutive cycles with `pat_valid` high. The first vector of the following non-empty entry appears in the very next cycle, and the total count of valid cycles equals the sum of all lengths.
- R5: An entry of length zero emits no vector and costs no cycle: the next non-empty entry follows the previous run directly.
- R6: In the cycle after the last vector, `pat_valid` is low and `done` is high. `done` stays high until `start` is seen, and `done` and `pat_valid` are never high together.
- R7: A run of 2^VEC_W or more vectors repeats its first vector for the first time at offset exactly 2^VEC_W.
- R8: `start` is ignored while a run is in progress, and the vector stream continues unchanged.
- R9: If every entry has length zero, `start` raises `done` on the next cycle and no vector is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches the list when no run is in progress |
| pattern | output | VEC_W | Current test vector |
| pat_valid | output | 1 | High while `pattern` carries a vector |
| done | output | 1 | High from the end of the list until the next start |

## Verification
A corrupted accumulator or addend shows up as a wrong `pattern` in the very next valid cycle. From then on the error persists for the rest of that run, because every vector inherits it. A wrong entry index or remaining-count shows up at a run boundary. The boundary arrives one cycle early or late, a vector from the wrong seed appears, or the total of valid cycles drifts from the sum of lengths. In every case the `done` edge moves away from its expected cycle. Every emitted vector is compared with a closed-form model, so a fault becomes visible within one cycle of reaching the outputs.

// File: rtl/pg_pkg.sv
package pg_pkg;

    // Operation applied to the accumulator register in a cycle
    typedef enum logic [1:0] {
        ACC_HOLD,
        ACC_CLEAR,
        ACC_LOAD,
        ACC_STEP
    } acc_op_e;

endpackage

// File: rtl/pg_accum.sv
module pg_accum
    import pg_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  acc_op_e          op,
    input  logic [VEC_W-1:0] load_val,
    input  logic [VEC_W-1:0] step_val,
    output logic [VEC_W-1:0] acc
);

    logic [VEC_W-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        case (op)
            ACC_CLEAR: acc_d = '0;
            ACC_LOAD:  acc_d = load_val;
            ACC_STEP:  acc_d = acc_q + step_val; // wraps modulo 2^VEC_W
            default:   acc_d = acc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    assign acc = acc_q;

endmodule

// File: rtl/pg_entry_sel.sv
// Finds the lowest table index at or above from_pos whose run length is non-zero.
module pg_entry_sel #(
    parameter int N_ENTRY = 5,
    parameter int LEN_W   = 9,
    parameter int IDX_W   = 3,
    parameter logic [LEN_W-1:0] LEN_TAB [N_ENTRY] = '{default: '0}
) (
    input  logic [IDX_W:0]   from_pos,
    output logic             found,
    output logic [IDX_W-1:0] sel
);

    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = N_ENTRY - 1; i >= 0; i--) begin
            if ((i >= int'(from_pos)) && (LEN_TAB[i] != '0)) begin
                found = 1'b1;
                sel   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/accum_pattern_gen.sv
module accum_pattern_gen
    import pg_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int N_ENTRY = 5,
    parameter int LEN_W   = 9,
    parameter logic [VEC_W-1:0] SEED_TAB [N_ENTRY] = '{8'h3C, 8'h77, 8'h00, 8'hFF, 8'h5A},
    parameter logic [LEN_W-1:0] LEN_TAB  [N_ENTRY] = '{9'd5, 9'd0, 9'd4, 9'd260, 9'd0}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic [VEC_W-1:0] pattern,
    output logic             pat_valid,
    output logic             done
);

    localparam int IDX_W = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [LEN_W-1:0] rem;
        logic             valid;
        logic             done;
    } ctl_t;

    ctl_t             c_d, c_q;
    acc_op_e          acc_op;
    logic [IDX_W:0]   from_pos;
    logic             nxt_found;
    logic [IDX_W-1:0] nxt_idx;
    logic [VEC_W-1:0] cur_inc;
    logic [VEC_W-1:0] nxt_seed;

    pg_entry_sel #(
        .N_ENTRY (N_ENTRY),
        .LEN_W   (LEN_W),
        .IDX_W   (IDX_W),
        .LEN_TAB (LEN_TAB)
    ) u_sel (
        .from_pos (from_pos),
        .found    (nxt_found),
        .sel      (nxt_idx)
    );

    assign nxt_seed = SEED_TAB[nxt_idx];
    // Addend is the stored word with its lowest bit forced high: always odd
    assign cur_inc  = SEED_TAB[c_q.idx] | VEC_W'(1);

    always_comb begin
        c_d      = c_q;
        acc_op   = ACC_HOLD;
        from_pos = '0;
        if (!c_q.valid) begin
            if (start) begin
                if (nxt_found) begin
                    c_d.idx   = nxt_idx;
                    c_d.rem   = LEN_TAB[nxt_idx];
                    c_d.valid = 1'b1;
                    c_d.done  = 1'b0;
                    acc_op    = ACC_LOAD;
                end else begin
                    c_d.done  = 1'b1;
                end
            end
        end else if (c_q.rem > LEN_W'(1)) begin
            c_d.rem = c_q.rem - LEN_W'(1);
            acc_op  = ACC_STEP;
        end else begin
            from_pos = {1'b0, c_q.idx} + (IDX_W + 1)'(1);
            if (nxt_found) begin
                c_d.idx = nxt_idx;
                c_d.rem = LEN_TAB[nxt_idx];
                acc_op  = ACC_LOAD;
            end else begin
                c_d.valid = 1'b0;
                c_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    pg_accum #(
        .VEC_W (VEC_W)
    ) u_acc (
        .clk      (clk),
        .rst      (rst),
        .op       (acc_op),
        .load_val (nxt_seed),
        .step_val (cur_inc),
        .acc      (pattern)
    );

    assign pat_valid = c_q.valid;
    assign done      = c_q.done;

endmodule

// File: rtl/pg_checker.sv
module pg_checker #(
    parameter int VEC_W   = 8,
    parameter int N_ENTRY = 5,
    parameter int LEN_W   = 9,
    parameter int IDX_W   = 3,
    parameter logic [VEC_W-1:0] SEED_TAB [N_ENTRY] = '{default: '0},
    parameter logic [LEN_W-1:0] LEN_TAB  [N_ENTRY] = '{default: '0}
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [VEC_W-1:0] pattern,
    input logic             pat_valid,
    input logic             done,
    input logic [IDX_W-1:0] run_idx,
    input logic [LEN_W-1:0] run_rem
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!pat_valid && !done && pattern == '0)); // R1

    AST_RUN_STEP: assert property (@(posedge clk) disable iff (rst)
        (pat_valid && $past(pat_valid) && run_idx == $past(run_idx))
        |-> pattern == VEC_W'($past(pattern) + (SEED_TAB[run_idx] | VEC_W'(1)))); // R3

    AST_RUN_LOAD: assert property (@(posedge clk) disable iff (rst)
        (pat_valid && (!$past(pat_valid) || run_idx != $past(run_idx)))
        |-> pattern == SEED_TAB[run_idx]); // R2

    AST_NO_EMPTY_RUN: assert property (@(posedge clk) disable iff (rst)
        pat_valid |-> (LEN_TAB[run_idx] != '0 && run_rem != '0)); // R5

    AST_VALID_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(pat_valid && done)); // R6

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && !pat_valid)); // R6

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (pat_valid && start && run_rem > LEN_W'(1)) |=> (pat_valid && run_idx == $past(run_idx))); // R8

endmodule

bind accum_pattern_gen pg_checker #(
    .VEC_W    (VEC_W),
    .N_ENTRY  (N_ENTRY),
    .LEN_W    (LEN_W),
    .IDX_W    (IDX_W),
    .SEED_TAB (SEED_TAB),
    .LEN_TAB  (LEN_TAB)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .pattern   (pattern),
    .pat_valid (pat_valid),
    .done      (done),
    .run_idx   (c_q.idx),
    .run_rem   (c_q.rem)
);

// File: tb/accum_pattern_gen_tb.sv
module accum_pattern_gen_tb;

    localparam int NE = 5;
    localparam logic [7:0] SEEDS [NE] = '{8'h3C, 8'h77, 8'h00, 8'hFF, 8'h5A};
    localparam logic [8:0] LENS  [NE] = '{9'd5, 9'd0, 9'd4, 9'd260, 9'd0};
    localparam logic [7:0] SEEDS_Z [2] = '{8'h11, 8'h22};
    localparam logic [8:0] LENS_Z  [2] = '{9'd0, 9'd0};

    logic       clk = 1'b0;
    logic       rst, start, start_z;
    logic [7:0] pattern, pattern_z;
    logic       pat_valid, done, valid_z, done_z;
    int         n_run = 0, n_fail = 0, vcnt = 0;

    always #2 clk = ~clk; // 250 MHz

    accum_pattern_gen #(
        .VEC_W(8), .N_ENTRY(NE), .LEN_W(9), .SEED_TAB(SEEDS), .LEN_TAB(LENS)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .pattern(pattern), .pat_valid(pat_valid), .done(done)
    );

    accum_pattern_gen #(
        .VEC_W(8), .N_ENTRY(2), .LEN_W(9), .SEED_TAB(SEEDS_Z), .LEN_TAB(LENS_Z)
    ) u_dut_z (
        .clk(clk), .rst(rst), .start(start_z),
        .pattern(pattern_z), .pat_valid(valid_z), .done(done_z)
    );

    always @(posedge clk) if (pat_valid) vcnt <= vcnt + 1;

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_main();
        int sum_len = 0;
        int repeats = 0;
        rst = 1'b1; start = 1'b0; start_z = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 valid", int'(pat_valid), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 pattern", int'(pattern), 0);
        rst = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // Walk the entry table; expected vector = seed + k*(seed|1) mod 256
        for (int e = 0; e < NE; e++) begin
            sum_len += int'(LENS[e]);
            for (int k = 0; k < int'(LENS[e]); k++) begin
                logic [7:0] expv;
                expv = 8'(int'(SEEDS[e]) + k * int'(SEEDS[e] | 8'h01));
                chk(k == 0 ? (e == 0 ? "R2 first" : "R4 R5 boundary") : "R3 step",
                    int'(pattern), int'(expv));
                chk("R4 valid", int'(pat_valid), 1);
                if (e == 3 && k > 0 && k < 256 && pattern == SEEDS[e]) repeats++;
                if (e == 3 && k == 256) chk("R7 period", int'(pattern), int'(SEEDS[e]));
                start = (e == 2 && k == 1); // R8: start pulse mid-run
                @(negedge clk);
            end
        end
        start = 1'b0;
        chk("R7 early repeat", repeats, 0);
        chk("R6 valid low", int'(pat_valid), 0);
        chk("R6 done", int'(done), 1);
        chk("R4 total", vcnt, sum_len);
        repeat (4) @(negedge clk);
        chk("R6 done held", int'(done), 1);
        chk("R6 valid held low", int'(pat_valid), 0);
        // Restart from done
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 restart pattern", int'(pattern), int'(SEEDS[0]));
        chk("R2 restart valid", int'(pat_valid), 1);
        chk("R6 done cleared", int'(done), 0);
        @(negedge clk);
        chk("R3 restart step", int'(pattern), int'(8'(SEEDS[0] + (SEEDS[0] | 8'h01))));
        // All-empty table
        start_z = 1'b1;
        @(negedge clk);
        start_z = 1'b0;
        chk("R9 done", int'(done_z), 1);
        chk("R9 valid", int'(valid_z), 0);
        // Reset in the middle of a run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid-run valid", int'(pat_valid), 0);
        chk("R1 mid-run pattern", int'(pattern), 0);
        chk("R1 mid-run done", int'(done), 0);
    endtask

    initial begin
        fork
            run_main();
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule